// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block turns a three-wire stereo audio stream (bit clock, word clock and serial data) into parallel 24-bit left and right samples. All three wires are brought into a free-running system clock domain through synchronizers. The bit clock is oversampled there, and each of its rising edges becomes a single-cycle bit tick. The word clock level is captured on every bit tick. A change of that level between two ticks marks the start of a new half-frame.

A static select input picks one of two alignments. In left-justified mode the most significant bit is the first bit of a half-frame and word clock high means left. In I2S mode the word is delayed by one bit clock and word clock low means left. Halves of 24 or 32 bit clocks are accepted, and any bit after the 24th of a word is dropped. When the two words of a frame are complete, both outputs are updated in the same cycle and a one-cycle strobe is raised.

Two watchdogs check the incoming clocks. One counts system cycles without a bit clock edge. The other counts bit ticks without a word clock change. If either reaches its limit, the block reports a lost clock, clears its outputs and discards any half-assembled frame.

Top module: `audio_serial_rx`

## Requirements
- R1: Serial data is sampled on each bit clock rising edge and assembled most significant bit first into a 24-bit two's-complement word. The output bits carry the received bits unchanged.
- R2: With `fmt_i2s` = 0, bit 23 of a word is the bit at the first rising edge after the word clock changes level, and word clock high carries the left channel.
- R3: With `fmt_i2s` = 1, bit 23 is the bit one rising edge after the word clock change, and word clock low carries the left channel. With 24-clock halves, bit 0 is the bit at the first rising edge of the following half.
- R4: Half-frames of 24 and of 32 bit clocks are both received correctly, and bits after the 24th bit of a word have no effect on the output samples.
- R5: Sources with 16-bit or 20-bit samples, sent with the unused low bits at zero, come out with exactly those zero low bits.
- R6: `left_sample` and `right_sample` change together, only in the cycle where `sample_valid` is high. `sample_valid` is a one-cycle pulse, raised once per frame after the last bit of the right word, and is never high in two consecutive cycles.
- R7: If the bit clock shows no edge for `STOP_LIMIT` (64) system clock cycles, `clk_lost` goes high. From the next cycle on, both samples are zero and `sample_valid` stays low.
- R8: If the bit clock runs but the word clock does not change level for `STOP_LIMIT` bit clock rising edges, `clk_lost` goes high, with the same effect on the outputs as in R7.
- R9: After reset, `clk_lost` is high and the samples are zero until both clocks toggle. After a loss, no frame is emitted unless a complete left word and then a complete right word have been received with `clk_lost` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | Serial bit clock, asynchronous to sys_clk |
| wclk | input | 1 | Word (channel select) clock |
| sdata | input | 1 | Serial audio data |
| fmt_i2s | input | 1 | 0 = left-justified, 1 = I2S alignment |
| left_sample | output | 24 | Last complete left-channel word |
| right_sample | output | 24 | Last complete right-channel word |
| sample_valid | output | 1 | One-cycle pulse when both samples update |
| clk_lost | output | 1 | High while either serial clock is considered stopped |

## Verification
Every word slot outside the 24 data bits is filled with random bits. A receiver that counts past the word, or that is one slot off in its alignment, therefore produces wrong samples instead of silently matching. The I2S case with 24-clock halves forces the last bit of the right word into the first slot of the next half. A design that drops that carried bit either emits no frame or emits a wrong least significant bit. Both stop conditions are driven on their own, and the outputs are checked to read zero afterwards. One stream is cut off after a complete left word, and a receiver that keeps that stale word across the loss would emit a spurious frame that no reference frame matches.

// File: rtl/ars_pkg.sv
package ars_pkg;
  localparam int SLOT_W = 6;
  typedef logic [SLOT_W-1:0] slot_t;
  localparam slot_t SLOT_MAX = '1;

  // Position of the current bit inside its channel word.
  // A value at or above the word width means the bit is not part of any word.
  function automatic slot_t word_index(input logic i2s, input logic flip,
                                       input slot_t old_s, input slot_t new_s);
    if (!i2s) return new_s;
    if (flip) return old_s;            // delayed LSB of the previous half
    return slot_t'(new_s - 1'b1);
  endfunction

  // Channel the current bit belongs to (1 = left).
  function automatic logic chan_is_left(input logic i2s, input logic flip,
                                        input logic wclk_now);
    if (!i2s) return wclk_now;
    return flip ? wclk_now : !wclk_now;
  endfunction
endpackage

// File: rtl/ars_sampler.sv
module ars_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic wclk,
  input  logic sdata,
  output logic bit_tick,
  output logic bclk_edge,
  output logic wclk_now,
  output logic wclk_flip,
  output logic sdata_now
);
  logic [SYNC_STAGES-1:0] sb, sw, sd;
  logic bclk_d, wclk_at_tick;
  logic bclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sb <= '0;
      sw <= '0;
      sd <= '0;
      bclk_d <= 1'b0;
      wclk_at_tick <= 1'b0;
    end else begin
      sb <= {sb[SYNC_STAGES-2:0], bclk};
      sw <= {sw[SYNC_STAGES-2:0], wclk};
      sd <= {sd[SYNC_STAGES-2:0], sdata};
      bclk_d <= bclk_s;
      if (bit_tick) wclk_at_tick <= wclk_now;
    end
  end

  assign bclk_s    = sb[SYNC_STAGES-1];
  assign wclk_now  = sw[SYNC_STAGES-1];
  assign sdata_now = sd[SYNC_STAGES-1];
  assign bit_tick  = bclk_s & ~bclk_d;
  assign bclk_edge = bclk_s ^ bclk_d;
  assign wclk_flip = bit_tick & (wclk_now ^ wclk_at_tick);

  // R1: one rising edge gives exactly one tick
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);
endmodule

// File: rtl/ars_stop_watch.sv
module ars_stop_watch #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic count_en,
  input  logic activity,
  output logic lost
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);
  logic [CW-1:0] idle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          idle_cnt <= TOP;
    else if (activity)                   idle_cnt <= '0;
    else if (count_en && idle_cnt != TOP) idle_cnt <= idle_cnt + 1'b1;
  end

  assign lost = (idle_cnt == TOP);

  // R9: activity always clears the loss indication
  assert_activity_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    activity |=> !lost);
  // R7 / R8: the last idle step raises the loss indication
  assert_limit_reached_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !activity && idle_cnt == TOP - 1'b1) |=> lost);
endmodule

// File: rtl/ars_deframer.sv
module ars_deframer
  import ars_pkg::*;
#(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fmt_i2s,
  input  logic         bit_tick,
  input  logic         wclk_now,
  input  logic         wclk_flip,
  input  logic         sdata_now,
  input  logic         lost,
  output logic [W-1:0] left_out,
  output logic [W-1:0] right_out,
  output logic         valid_out
);
  slot_t slot_q, slot_new, idx;
  logic [W-1:0] acc_l, acc_r;
  logic have_left;
  logic is_left, in_word, last_bit, left_done, right_done, emit;

  function automatic logic [W-1:0] put_bit(input logic [W-1:0] a, input slot_t i,
                                           input logic b);
    logic [W-1:0] r;
    r = (i == '0) ? '0 : a;
    r[W-1-int'(i)] = b;
    return r;
  endfunction

  always_comb begin
    slot_new   = wclk_flip ? '0 : ((slot_q == SLOT_MAX) ? SLOT_MAX : slot_t'(slot_q + 1'b1));
    idx        = word_index(fmt_i2s, wclk_flip, slot_q, slot_new);
    is_left    = chan_is_left(fmt_i2s, wclk_flip, wclk_now);
    in_word    = bit_tick && (int'(idx) < W);
    last_bit   = in_word && (int'(idx) == W - 1);
    left_done  = last_bit && is_left;
    right_done = last_bit && !is_left;
    emit       = right_done && have_left && !lost;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q    <= SLOT_MAX;
      acc_l     <= '0;
      acc_r     <= '0;
      have_left <= 1'b0;
      left_out  <= '0;
      right_out <= '0;
      valid_out <= 1'b0;
    end else begin
      valid_out <= 1'b0;
      if (bit_tick)  slot_q <= slot_new;
      else if (lost) slot_q <= SLOT_MAX;
      if (in_word) begin
        if (is_left) acc_l <= put_bit(acc_l, idx, sdata_now);
        else         acc_r <= put_bit(acc_r, idx, sdata_now);
      end
      if (lost) begin
        have_left <= 1'b0;
        left_out  <= '0;
        right_out <= '0;
      end else if (emit) begin
        left_out  <= acc_l;
        right_out <= put_bit(acc_r, idx, sdata_now);
        valid_out <= 1'b1;
        have_left <= 1'b0;
      end else if (left_done) begin
        have_left <= 1'b1;
      end
    end
  end

  // R6: the strobe follows a bit tick and never lasts two cycles
  assert_valid_after_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |-> $past(bit_tick));
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_out |=> !valid_out);
  // R7: a lost clock clears the samples and blocks the strobe
  assert_lost_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lost |=> (left_out == '0 && right_out == '0 && !valid_out));
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int SAMPLE_W    = 24,
  parameter int STOP_LIMIT  = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic                sys_clk,
  input  logic                rst_n,
  input  logic                bclk,
  input  logic                wclk,
  input  logic                sdata,
  input  logic                fmt_i2s,
  output logic [SAMPLE_W-1:0] left_sample,
  output logic [SAMPLE_W-1:0] right_sample,
  output logic                sample_valid,
  output logic                clk_lost
);
  logic bit_tick, bclk_edge, wclk_now, wclk_flip, sdata_now;
  logic bclk_lost, wclk_lost;

  ars_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(sys_clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
    .bit_tick(bit_tick), .bclk_edge(bclk_edge), .wclk_now(wclk_now),
    .wclk_flip(wclk_flip), .sdata_now(sdata_now)
  );

  // bit clock watched in system cycles
  ars_stop_watch #(.LIMIT(STOP_LIMIT)) u_bclk_watch (
    .clk(sys_clk), .rst_n(rst_n), .count_en(1'b1), .activity(bclk_edge),
    .lost(bclk_lost)
  );

  // word clock watched in bit clock ticks
  ars_stop_watch #(.LIMIT(STOP_LIMIT)) u_wclk_watch (
    .clk(sys_clk), .rst_n(rst_n), .count_en(bit_tick), .activity(wclk_flip),
    .lost(wclk_lost)
  );

  assign clk_lost = bclk_lost | wclk_lost;

  ars_deframer #(.W(SAMPLE_W)) u_deframer (
    .clk(sys_clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .bit_tick(bit_tick),
    .wclk_now(wclk_now), .wclk_flip(wclk_flip), .sdata_now(sdata_now),
    .lost(clk_lost), .left_out(left_sample), .right_out(right_sample),
    .valid_out(sample_valid)
  );
endmodule

// File: tb/sim_audio_serial_rx.sv
module sim_audio_serial_rx;
  localparam int CLK_PERIOD = 10;
  localparam int BHALF = 4;
  localparam int LEAD = 4;
  localparam int MAXP = 512;

  logic clk = 0, rst_n = 0, bclk = 0, wclk = 0, sdata = 0, fmt = 0;
  logic [23:0] left_s, right_s;
  logic valid, clk_lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_serial_rx u0 (
    .sys_clk(clk), .rst_n(rst_n), .bclk(bclk), .wclk(wclk), .sdata(sdata),
    .fmt_i2s(fmt), .left_sample(left_s), .right_sample(right_s),
    .sample_valid(valid), .clk_lost(clk_lost)
  );

  typedef struct packed { logic [23:0] l; logic [23:0] r; } fr_t;
  fr_t exp_q[$];
  fr_t cur = '0;
  logic lost_prev = 1'b1;
  int checks = 0, fails = 0;
  bit active = 0, done = 0;
  string cur_tag = "";

  task automatic chk(input bit ok, input string tag, input logic [47:0] act,
                     input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle reference comparison
  always @(negedge clk) begin
    if (active) begin
      if (valid) begin
        if (exp_q.size() == 0)
          chk(0, {"R6 unexpected frame ", cur_tag}, {left_s, right_s}, 48'h0);
        else begin
          fr_t e;
          e = exp_q.pop_front();
          chk({left_s, right_s} == e, {"R6 frame ", cur_tag}, {left_s, right_s}, e);
          cur = e;
        end
      end else if (lost_prev)
        chk({left_s, right_s} == 48'h0, "R7 R8 samples zero while lost", {left_s, right_s}, 48'h0);
      else
        chk({left_s, right_s} == cur, {"R6 hold between frames ", cur_tag}, {left_s, right_s}, cur);
      if (clk_lost) cur = '0;
      lost_prev = clk_lost;
    end
  end

  task automatic drive_bit(input logic w, input logic d);
    wclk = w;
    sdata = d;
    repeat (BHALF) @(negedge clk);
    bclk = 1;
    repeat (BHALF) @(negedge clk);
    bclk = 0;
  endtask

  // builds a stream: lead-in, nfr frames, one trailing half; cut > 0 truncates
  task automatic send(input logic fmt_v, input int half, input int nfr, input int width,
                      input int cut, input string tag);
    logic bits [MAXP];
    logic wcs [MAXP];
    int total, offs, limit, rpos;
    logic lvl_left;
    logic [23:0] mask, l, r;
    cur_tag = tag;
    fmt = fmt_v;
    lvl_left = fmt_v ? 1'b0 : 1'b1;
    offs = fmt_v ? 1 : 0;
    total = LEAD + 2 * nfr * half + half;
    mask = (width == 24) ? 24'hFFFFFF : (width == 20) ? 24'hFFFFF0 : 24'hFFFF00;
    for (int p = 0; p < total; p++) begin
      bits[p] = 1'($urandom % 2);
      if (p < LEAD) wcs[p] = !lvl_left;
      else wcs[p] = ((((p - LEAD) / half) % 2) == 0) ? lvl_left : !lvl_left;
    end
    for (int f = 0; f < nfr; f++) begin
      l = 24'($urandom) & mask;
      r = 24'($urandom) & mask;
      if (f == 0) begin l = 24'h800000; r = 24'h7FFFFF & mask; end
      for (int i = 0; i < 24; i++) begin
        bits[LEAD + 2*f*half + offs + i]     = l[23-i];
        bits[LEAD + (2*f+1)*half + offs + i] = r[23-i];
      end
      rpos = LEAD + (2*f+1)*half + offs + 23;
      if (cut == 0 || rpos < cut) exp_q.push_back({l, r});
    end
    limit = (cut > 0) ? cut : total;
    for (int p = 0; p < limit; p++) drive_bit(wcs[p], bits[p]);
  endtask

  task automatic stop_and_check(input string tag);
    chk(clk_lost == 1'b0, {"R7 clocks running ", tag}, 48'(clk_lost), 48'h0);
    repeat (80) @(negedge clk);
    chk(clk_lost == 1'b1, {"R7 bit clock stopped ", tag}, 48'(clk_lost), 48'h1);
    chk({left_s, right_s} == 48'h0, {"R7 samples cleared ", tag}, {left_s, right_s}, 48'h0);
    chk(exp_q.size() == 0, {"R6 all frames emitted ", tag}, 48'(exp_q.size()), 48'h0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(clk_lost == 1'b1, "R9 reset lost flag", 48'(clk_lost), 48'h1);
    chk({left_s, right_s} == 48'h0, "R9 reset samples", {left_s, right_s}, 48'h0);
    chk(valid == 1'b0, "R6 reset strobe", 48'(valid), 48'h0);
    rst_n = 1;
    @(negedge clk);
    active = 1;

    send(1'b0, 32, 6, 24, 0, "R1 R2 R4 left-justified 32-clock halves");
    stop_and_check("R2");
    send(1'b1, 32, 5, 24, 0, "R1 R3 R4 I2S 32-clock halves");
    stop_and_check("R3");
    send(1'b1, 24, 5, 24, 0, "R3 R4 I2S 24-clock halves carried LSB");
    stop_and_check("R4");
    send(1'b0, 24, 4, 16, 0, "R5 16-bit left-justified");
    for (int k = 0; k < 80; k++) drive_bit(wclk, 1'($urandom % 2));
    chk(clk_lost == 1'b1, "R8 word clock stopped", 48'(clk_lost), 48'h1);
    chk({left_s, right_s} == 48'h0, "R8 samples cleared", {left_s, right_s}, 48'h0);
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 0, "R6 all frames emitted R5", 48'(exp_q.size()), 48'h0);
    exp_q.delete();
    send(1'b1, 32, 4, 20, 0, "R5 20-bit I2S");
    stop_and_check("R5");
    send(1'b0, 32, 3, 24, LEAD + 3*32 + 10, "R9 stream cut after left word");
    repeat (80) @(negedge clk);
    chk(exp_q.size() == 0, "R9 only complete frames emitted", 48'(exp_q.size()), 48'h0);
    exp_q.delete();
    send(1'b0, 32, 2, 24, 0, "R9 recovery after loss");
    stop_and_check("R9");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R6 run did not complete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule